// File: doc/BRIEF.md
# Receive Descriptor Timestamp and Sequence Stamper

This block sits where a finished receive packet descriptor is handed to a notification ring. It records the local time at every start-of-packet strobe in a small in-order queue. When the matching descriptor arrives, the block completes three descriptor fields. Each field is filled either by hardware or with the classifier's own content, according to per-packet enable bits.

The three fields are a 64-bit timestamp (seconds and nanoseconds), a 48-bit running packet sequence number, and a 16-bit general-purpose sequence field. The general-purpose field, when enabled, carries a selector that picks one counter from a bank. The selected counter's value is then written over the whole field.

Every descriptor carries a 2-bit delivery code from the classifier. Code 00 discards both packet and descriptor. Code 01 delivers both. Code 10 delivers only the descriptor. Code 11 is treated like a delivered code. A discarded descriptor produces no output and advances no counter.

Top module: `rx_desc_stamper`

## Requirements
- R1: After reset `desc_valid_o` is low, the queue is empty, and every counter is zero, so the first delivered descriptor gets packet sequence 0 and each general-purpose counter first yields 0.
- R2: A descriptor on `desc_valid_i` appears on the outputs exactly one cycle later if its `drop_i` code is not 00, with `dest_o` equal to that code; a code of 00 gives no `desc_valid_o` pulse.
- R3: Each `sop_i` pushes {`now_sec_i`,`now_ns_i`} into a queue of depth TSQ_DEPTH; each descriptor pops the oldest entry, and with `ts_en_i` high the popped time is written to `ts_sec_o`/`ts_ns_o`.
- R4: With `ts_en_i` low the custom timestamp inputs pass unchanged to the outputs, and the queue is still popped.
- R5: A descriptor that finds the queue empty uses the current time if `sop_i` is high in the same cycle (that strobe is then not queued), and zero otherwise.
- R6: A `sop_i` arriving while the queue is full and nothing is popped that cycle is ignored; a pop and a push in the same cycle on a full queue both take effect.
- R7: With `psqn_en_i` high `psqn_o` is the packet counter value, otherwise `cust_psqn_i`; the counter advances by one after every delivered descriptor, whether enabled or not.
- R8: A descriptor with code 00 leaves the packet counter and every general-purpose counter unchanged.
- R9: With `gp_en_i` high the low 13 bits of `gp_field_i` select a counter whose 16-bit value replaces the field, after which that counter increments (wrapping); with `gp_en_i` low `gp_field_i` passes through.
- R10: A selector of GP_NUM or above yields zero in `gp_o` and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Start-of-packet strobe from the MAC side |
| now_ns_i | input | NS_W | Current time, nanoseconds part |
| now_sec_i | input | SEC_W | Current time, seconds part |
| desc_valid_i | input | 1 | Descriptor ready for the notification ring |
| drop_i | input | 2 | Delivery code (00 drop all, 01 both, 10 descriptor only) |
| ts_en_i | input | 1 | Insert hardware timestamp |
| psqn_en_i | input | 1 | Insert packet sequence number |
| gp_en_i | input | 1 | Replace general-purpose field by selected counter |
| cust_ns_i | input | NS_W | Classifier timestamp nanoseconds |
| cust_sec_i | input | SEC_W | Classifier timestamp seconds |
| cust_psqn_i | input | PSQN_W | Classifier packet sequence content |
| gp_field_i | input | GP_W | Classifier general-purpose field or selector |
| desc_valid_o | output | 1 | Completed descriptor valid |
| dest_o | output | 2 | Delivery code of the completed descriptor |
| ts_ns_o | output | NS_W | Timestamp nanoseconds out |
| ts_sec_o | output | SEC_W | Timestamp seconds out |
| psqn_o | output | PSQN_W | Packet sequence field out |
| gp_o | output | GP_W | General-purpose field out |

## Verification
Every completed field is due one clock after the edge that accepts the descriptor. Timestamps are due from the edge of their own `sop_i`, which may be many cycles earlier. The reference model evaluates the inputs at each rising edge and holds its predictions. The bench compares them on the next falling edge, once the single output register has settled. Field values are compared only on cycles with an expected valid pulse, because outputs of discarded descriptors carry no meaning.

// File: rtl/rx_desc_stamper.sv
module rx_desc_stamper #(
  parameter int NS_W      = 32,
  parameter int SEC_W     = 32,
  parameter int PSQN_W    = 48,
  parameter int GP_W      = 16,
  parameter int SEL_W     = 13,
  parameter int GP_NUM    = 12,
  parameter int TSQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic [NS_W-1:0]   now_ns_i,
  input  logic [SEC_W-1:0]  now_sec_i,
  input  logic              desc_valid_i,
  input  logic [1:0]        drop_i,
  input  logic              ts_en_i,
  input  logic              psqn_en_i,
  input  logic              gp_en_i,
  input  logic [NS_W-1:0]   cust_ns_i,
  input  logic [SEC_W-1:0]  cust_sec_i,
  input  logic [PSQN_W-1:0] cust_psqn_i,
  input  logic [GP_W-1:0]   gp_field_i,
  output logic              desc_valid_o,
  output logic [1:0]        dest_o,
  output logic [NS_W-1:0]   ts_ns_o,
  output logic [SEC_W-1:0]  ts_sec_o,
  output logic [PSQN_W-1:0] psqn_o,
  output logic [GP_W-1:0]   gp_o
);
  localparam int TS_W = NS_W + SEC_W;
  localparam int QAW  = (TSQ_DEPTH > 1) ? $clog2(TSQ_DEPTH) : 1;
  localparam int QCW  = $clog2(TSQ_DEPTH + 1);
  localparam logic [1:0] DROP_ALL = 2'b00;

  logic [TS_W-1:0]   tsq [TSQ_DEPTH];
  logic [QAW-1:0]    rd_ptr, wr_ptr;
  logic [QCW-1:0]    q_cnt;
  logic [PSQN_W-1:0] psqn_cnt;
  logic [GP_W-1:0]   gp_cnt [GP_NUM];
  logic [GP_W-1:0]   gp_rd;

  wire q_empty = (q_cnt == '0);
  wire q_full  = (q_cnt == QCW'(TSQ_DEPTH));
  wire [TS_W-1:0] now_ts = {now_sec_i, now_ns_i};
  wire q_rd   = desc_valid_i && !q_empty;
  wire bypass = desc_valid_i && q_empty && sop_i;
  wire q_wr   = sop_i && !bypass && (!q_full || q_rd);
  wire keep   = desc_valid_i && (drop_i != DROP_ALL);
  wire [TS_W-1:0] hw_ts = q_rd ? tsq[rd_ptr] : (bypass ? now_ts : '0);

  wire [SEL_W-1:0] sel    = gp_field_i[SEL_W-1:0];
  wire             sel_ok = (sel < SEL_W'(GP_NUM));
  wire             gp_hit = keep && gp_en_i && sel_ok;

  function automatic logic [QAW-1:0] nxt(input logic [QAW-1:0] p);
    return (p == QAW'(TSQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (q_wr) tsq[wr_ptr] <= now_ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (q_rd) rd_ptr <= nxt(rd_ptr);
      if (q_wr) wr_ptr <= nxt(wr_ptr);
      q_cnt <= q_cnt + QCW'(q_wr) - QCW'(q_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    psqn_cnt <= '0;
    else if (keep) psqn_cnt <= psqn_cnt + 1'b1;
  end

  for (genvar g = 0; g < GP_NUM; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rst_n)                                gp_cnt[g] <= '0;
      else if (gp_hit && sel == SEL_W'(g))       gp_cnt[g] <= gp_cnt[g] + 1'b1;
    end
  end

  always_comb begin
    gp_rd = '0;
    for (int k = 0; k < GP_NUM; k++)
      if (sel == SEL_W'(k)) gp_rd = gp_cnt[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid_o <= 1'b0;
      dest_o       <= '0;
      ts_ns_o      <= '0;
      ts_sec_o     <= '0;
      psqn_o       <= '0;
      gp_o         <= '0;
    end else begin
      desc_valid_o <= keep;
      if (desc_valid_i) begin
        dest_o              <= drop_i;
        {ts_sec_o, ts_ns_o} <= ts_en_i ? hw_ts : {cust_sec_i, cust_ns_i};
        psqn_o              <= psqn_en_i ? psqn_cnt : cust_psqn_i;
        gp_o                <= gp_en_i ? (sel_ok ? gp_rd : '0) : gp_field_i;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> desc_valid_o && dest_o == $past(drop_i));
  assert_drop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> !desc_valid_o);
  assert_custom_ts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    keep && !ts_en_i |=> ts_ns_o == $past(cust_ns_i) && ts_sec_o == $past(cust_sec_i));
  assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCW'(TSQ_DEPTH));
  assert_psqn_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> psqn_cnt == $past(psqn_cnt) + 1'b1);
  assert_drop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_i && drop_i == DROP_ALL |=> $stable(psqn_cnt));
  assert_sel_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    keep && gp_en_i && !sel_ok |=> gp_o == '0);
endmodule

// File: tb/tb_rx_desc_stamper.sv
module tb_rx_desc_stamper;
  localparam int GP_NUM = 12;
  localparam int DEPTH  = 4;
  localparam longint unsigned PMASK = 64'hFFFF_FFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic sop = 0, desc_v = 0, ts_en = 0, ps_en = 0, gp_en = 0;
  logic [1:0] drop = 0;
  logic [31:0] now_ns = 0, now_sec = 0, cns = 0, csec = 0;
  logic [47:0] cps = 0;
  logic [15:0] gpf = 0;
  logic dv_o;
  logic [1:0] dest_o;
  logic [31:0] ns_o, sec_o;
  logic [47:0] ps_o;
  logic [15:0] gp_o;

  always #10 clk = ~clk;

  rx_desc_stamper #(.GP_NUM(GP_NUM), .TSQ_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .now_ns_i(now_ns), .now_sec_i(now_sec),
    .desc_valid_i(desc_v), .drop_i(drop), .ts_en_i(ts_en), .psqn_en_i(ps_en),
    .gp_en_i(gp_en), .cust_ns_i(cns), .cust_sec_i(csec), .cust_psqn_i(cps),
    .gp_field_i(gpf), .desc_valid_o(dv_o), .dest_o(dest_o), .ts_ns_o(ns_o),
    .ts_sec_o(sec_o), .psqn_o(ps_o), .gp_o(gp_o));

  int checks = 0, failures = 0, cyc = 0;

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    now_ns  <= cyc * 20;
    now_sec <= cyc / 50;
  end

  bit [63:0] q[$];
  longint unsigned psqn;
  int unsigned gpc [GP_NUM];
  bit mv = 0, e_dv = 0, popped;
  bit [1:0] e_dest;
  bit [63:0] ts_hw, e_ts;
  longint unsigned e_ps;
  int unsigned e_gp, sel;
  string ts_tag, ps_tag, gp_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); psqn = 0; mv = 0; e_dv = 0;
      foreach (gpc[i]) gpc[i] = 0;
    end else begin
      e_dv = 0; popped = 0;
      if (desc_v) begin
        if (q.size() > 0) begin ts_hw = q.pop_front(); popped = 1; ts_tag = "R3/R6"; end
        else if (sop) begin ts_hw = {now_sec, now_ns}; ts_tag = "R5"; end
        else begin ts_hw = 0; ts_tag = "R5"; end
        e_dv = (drop != 2'b00);
        e_dest = drop;
        e_ts = ts_en ? ts_hw : {csec, cns};
        if (!ts_en) ts_tag = "R4";
        e_ps = ps_en ? psqn : cps;
        ps_tag = (ps_en && psqn == 0) ? "R1/R7" : "R7/R8";
        sel = gpf[12:0];
        if (!gp_en) begin e_gp = gpf; gp_tag = "R9"; end
        else if (sel < GP_NUM) begin
          e_gp = gpc[sel] & 16'hFFFF; gp_tag = "R9/R8";
          if (e_dv) gpc[sel] = (gpc[sel] + 1) & 16'hFFFF;
        end else begin e_gp = 0; gp_tag = "R10"; end
        if (e_dv) psqn = (psqn + 1) & PMASK;
      end
      if (sop && !(desc_v && !popped) && q.size() < DEPTH) q.push_back({now_sec, now_ns});
      mv = 1;
    end
  end

  always @(negedge clk) begin
    if (mv) begin
      check("R2 valid", dv_o, e_dv);
      if (e_dv) begin
        check("R2 dest", dest_o, e_dest);
        check({ts_tag, " ns"}, ns_o, e_ts[31:0]);
        check({ts_tag, " sec"}, sec_o, e_ts[63:32]);
        check(ps_tag, ps_o, e_ps);
        check(gp_tag, gp_o, e_gp);
      end
    end
  end

  task automatic step(input bit s, d, input logic [1:0] dr, input bit te, pe, ge,
                      input logic [15:0] gf);
    @(negedge clk);
    sop = s; desc_v = d; drop = dr; ts_en = te; ps_en = pe; gp_en = ge; gpf = gf;
    cns = $urandom; csec = $urandom; cps = {16'($urandom), 32'($urandom)};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'b01, 0, 0, 0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset valid", dv_o, 0);
    check("R1 reset psqn", ps_o, 0);
    // R3: queued timestamps, hardware fields
    step(1, 0, 2'b01, 0, 0, 0, 0); idle(2);
    step(1, 0, 2'b01, 0, 0, 0, 0); idle(1);
    step(0, 1, 2'b01, 1, 1, 1, 16'd3);
    step(0, 1, 2'b10, 1, 1, 1, 16'd3);
    idle(2);
    // R4: custom timestamp still pops
    step(1, 0, 2'b01, 0, 0, 0, 0);
    step(0, 1, 2'b01, 0, 1, 0, 16'hABCD);
    // R8: dropped descriptors
    step(1, 1, 2'b00, 1, 1, 1, 16'd3);
    step(0, 1, 2'b00, 1, 1, 1, 16'd5);
    step(0, 1, 2'b11, 1, 1, 1, 16'd3);
    // R5: empty queue with and without SOP
    idle(2);
    step(1, 1, 2'b01, 1, 1, 0, 16'h1234);
    step(0, 1, 2'b01, 1, 0, 0, 16'h5678);
    // R6: overfill, then full push+pop
    for (int i = 0; i < 6; i++) step(1, 0, 2'b01, 0, 0, 0, 0);
    step(1, 1, 2'b01, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 2'b01, 1, 1, 0, 0);
    // R10: out-of-range selectors, R9 top index
    step(0, 1, 2'b01, 0, 0, 1, 16'd12);
    step(0, 1, 2'b01, 0, 0, 1, 16'h1FFF);
    step(0, 1, 2'b01, 0, 0, 1, 16'hE000 | 16'd11);
    step(0, 1, 2'b01, 0, 0, 1, 16'd11);
    for (int i = 0; i < 600; i++)
      step($urandom % 2, ($urandom % 3) == 0, 2'($urandom), $urandom % 2, $urandom % 2,
           $urandom % 2, ($urandom % 2) ? 16'($urandom % 14) : 16'($urandom));
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule